// File: doc/BRIEF.md
# Event-Framed Sample Derandomizer Writer

This block sits behind a pipelined ADC on the convert clock. It collects one event's worth of samples into an on-chip FIFO, so that a slower consumer with a variable processing time can take the samples at its own pace. An external start strobe opens an event and an external stop strobe closes it. In between, one word is stored on every clock. Each word packs the sample with a small event tag and the two framing markers. The ADC returns each conversion a fixed number of clocks after the analog sample it belongs to. The block therefore delays the strobes and the tag by the same number of clocks, so that each marker is stored with the matching data.

The consumer sees the oldest word at once and removes it with a pop strobe. A counter of completed events tells the consumer when at least one whole event is waiting. The counter goes up when an accepted word carries the stop marker and goes down when the consumer pops such a word. An occupancy threshold, loaded before acquisition, drives an almost-full flag. The threshold is set so that one more whole event still fits above it. That flag drives an active pull-down busy output, and the pull-down outputs of several boards can share one wired line that holds off the trigger. If a word arrives while the FIFO is full, the word is dropped and a sticky overflow flag is set.

Top module: `evt_derand_writer`

## Requirements
- R1: A stored word holds the sample in bits [9:0], the tag in bits [13:10], the stop marker in bit 14 and the start marker in bit 15 (defaults DATA_W=10, TAG_W=4).
- R2: The start strobe, stop strobe and tag presented in cycle c are stored with the value seen on `sampleIn` in cycle c+ADC_LAT (default 4).
- R3: A start strobe opens capture. One word is written per clock, up to and including the word that carries the stop marker. No word is written while no event is open.
- R4: A stop strobe that arrives while no event is open and without a start strobe in the same cycle writes no word and leaves `eventsReady` unchanged.
- R5: Every accepted write of a word that carries the stop marker adds one to `eventsReady`.
- R6: Every pop of a word that carries the stop marker subtracts one from `eventsReady`. When such a pop and such a write fall in the same cycle, the count does not change.
- R7: Words leave in the order they were written. `rdWord` shows the oldest word whenever `rdValid` is high. A pop while the FIFO is empty has no effect.
- R8: `almostFull` and `busyPullDown` are high exactly when the occupancy is greater than `afLevel`.
- R9: A write attempted while the FIFO holds DEPTH words is dropped and sets `overflow`. `overflow` stays high until reset. A dropped stop word does not count as an event.
- R10: After reset the FIFO is empty, `eventsReady` is 0, and `overflow`, `almostFull` and `busyPullDown` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC convert clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | DATA_W | ADC output, ADC_LAT clocks behind its sample |
| startIn | input | 1 | Start-of-event strobe, aligned with the analog sample |
| stopIn | input | 1 | Stop-of-event strobe, aligned with the analog sample |
| tagIn | input | TAG_W | Event tag, aligned with the analog sample |
| afLevel | input | $clog2(DEPTH)+1 | Almost-full occupancy threshold |
| popIn | input | 1 | Consumer pop strobe |
| rdWord | output | DATA_W+TAG_W+2 | Oldest stored word |
| rdValid | output | 1 | FIFO is not empty |
| eventsReady | output | CNT_W | Number of complete events held |
| almostFull | output | 1 | Occupancy is above `afLevel` |
| busyPullDown | output | 1 | Enables the pull-down on the shared busy line |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Two things can happen in the same clock: the event counter can be raised by a stop word being written and lowered by a stop word being popped. The bench provokes this directly. It leaves a single-word event in the FIFO and then schedules a pop so that it falls exactly on the clock where a new single-word event's stop word arrives after the ADC latency. The count must stay at one. The same collision also occurs freely in a streaming phase with back-to-back events and continuous popping, which is judged by a zero count once the FIFO has drained and by the scoreboard's word-for-word order.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Strobes handed from framing control to the storage datapath.
  typedef struct packed {
    logic pushReq;    // a word is due this cycle
    logic markStart;  // the word opens an event
    logic markStop;   // the word closes an event
  } ctrlStb_t;

endpackage

// File: rtl/evt_align.sv
module evt_align #(
  parameter int LAT   = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             stopIn,
  input  logic [TAG_W-1:0] tagIn,
  output logic             dStart,
  output logic             dStop,
  output logic [TAG_W-1:0] dTag
);
  localparam int STAGE_W = TAG_W + 2;

  generate
    if (LAT == 0) begin : g_pass
      assign {dStart, dStop, dTag} = {startIn, stopIn, tagIn};
    end else begin : g_pipe
      logic [STAGE_W-1:0] stage [LAT];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < LAT; i++) stage[i] <= '0;
        end else begin
          stage[0] <= {startIn, stopIn, tagIn};
          for (int i = 1; i < LAT; i++) stage[i] <= stage[i-1];
        end
      end

      assign {dStart, dStop, dTag} = stage[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dStart,
  input  logic                dStop,
  input  logic                full,
  input  logic                popStop,
  output evt_pkg::ctrlStb_t   stb,
  output logic [CNT_W-1:0]    eventsReady,
  output logic                overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic inEvent;
  logic writeNow;
  logic stopAccepted;

  assign writeNow = dStart | inEvent;

  always_comb begin
    stb.pushReq   = writeNow;
    stb.markStart = dStart;
    stb.markStop  = dStop & writeNow;
  end

  assign stopAccepted = stb.pushReq & stb.markStop & ~full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inEvent <= 1'b0;
    end else begin
      // framing closes on the stop marker whether or not the word fits
      inEvent <= writeNow & ~dStop;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventsReady <= '0;
    end else begin
      unique case ({stopAccepted, popStop})
        2'b10:   if (eventsReady != CNT_MAX) eventsReady <= eventsReady + 1'b1;
        2'b01:   if (eventsReady != '0)      eventsReady <= eventsReady - 1'b1;
        default: eventsReady <= eventsReady;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overflow <= 1'b0;
    else if (stb.pushReq && full) overflow <= 1'b1;
  end
endmodule

// File: rtl/evt_store.sv
module evt_store #(
  parameter int DATA_W = 10,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 1024
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  evt_pkg::ctrlStb_t             stb,
  input  logic [DATA_W-1:0]             sampleIn,
  input  logic [TAG_W-1:0]              dTag,
  input  logic                          popIn,
  input  logic [$clog2(DEPTH):0]        afLevel,
  output logic [DATA_W+TAG_W+1:0]       rdWord,
  output logic                          rdValid,
  output logic                          full,
  output logic                          almostFull,
  output logic                          popStop
);
  localparam int AW      = $clog2(DEPTH);
  localparam int WORD_W  = DATA_W + TAG_W + 2;
  localparam int STOP_B  = WORD_W - 2;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_OCC = (AW+1)'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [AW:0]       occ;
  logic              pushOk;
  logic              popOk;

  assign full    = (occ == FULL_OCC);
  assign rdValid = (occ != '0);
  assign pushOk  = stb.pushReq & ~full;
  assign popOk   = popIn & rdValid;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= {stb.markStart, stb.markStop, dTag, sampleIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      unique case ({pushOk, popOk})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign rdWord     = mem[rdPtr];
  assign almostFull = (occ > afLevel);
  assign popStop    = popOk & rdWord[STOP_B];
endmodule

// File: rtl/evt_derand_writer.sv
module evt_derand_writer #(
  parameter int DATA_W  = 10,
  parameter int TAG_W   = 4,
  parameter int ADC_LAT = 4,
  parameter int DEPTH   = 1024,
  parameter int CNT_W   = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W-1:0]             sampleIn,
  input  logic                          startIn,
  input  logic                          stopIn,
  input  logic [TAG_W-1:0]              tagIn,
  input  logic [$clog2(DEPTH):0]        afLevel,
  input  logic                          popIn,
  output logic [DATA_W+TAG_W+1:0]       rdWord,
  output logic                          rdValid,
  output logic [CNT_W-1:0]              eventsReady,
  output logic                          almostFull,
  output logic                          busyPullDown,
  output logic                          overflow
);
  evt_pkg::ctrlStb_t ctrlStb;
  logic              dStart;
  logic              dStop;
  logic [TAG_W-1:0]  dTag;
  logic              storeFull;
  logic              popStop;

  evt_align #(.LAT(ADC_LAT), .TAG_W(TAG_W)) u_align (
    .clk(clk), .rstN(rstN),
    .startIn(startIn), .stopIn(stopIn), .tagIn(tagIn),
    .dStart(dStart), .dStop(dStop), .dTag(dTag)
  );

  evt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .dStart(dStart), .dStop(dStop),
    .full(storeFull), .popStop(popStop),
    .stb(ctrlStb), .eventsReady(eventsReady), .overflow(overflow)
  );

  evt_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN),
    .stb(ctrlStb), .sampleIn(sampleIn), .dTag(dTag),
    .popIn(popIn), .afLevel(afLevel),
    .rdWord(rdWord), .rdValid(rdValid),
    .full(storeFull), .almostFull(almostFull), .popStop(popStop)
  );

  assign busyPullDown = almostFull;
endmodule

// File: rtl/evt_derand_chk.sv
module evt_derand_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              popIn,
  input logic              rdValid,
  input logic [WORD_W-1:0] rdWord,
  input logic [CNT_W-1:0]  eventsReady,
  input logic              overflow,
  input logic              busyPullDown,
  input logic              pushReq,
  input logic              markStop,
  input logic              full
);
  localparam int STOP_B = WORD_W - 2;

  logic stopIn_w;
  logic stopOut_w;
  assign stopIn_w  = pushReq & markStop & ~full;
  assign stopOut_w = popIn & rdValid & rdWord[STOP_B];

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9
  full_write_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && full) |=> overflow);

  // R5
  event_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopIn_w && !stopOut_w && eventsReady != '1) |=>
      eventsReady == CNT_W'($past(eventsReady) + 1'b1));

  // R6
  event_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopOut_w && !stopIn_w) |=>
      eventsReady == CNT_W'($past(eventsReady) - 1'b1));

  // R6
  event_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopOut_w && stopIn_w) |=> $stable(eventsReady));

  // R7
  ready_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventsReady != '0) |-> rdValid);

  // R8
  empty_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> !busyPullDown);
endmodule

bind evt_derand_writer evt_derand_chk #(
  .WORD_W(DATA_W + TAG_W + 2), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .popIn(popIn), .rdValid(rdValid), .rdWord(rdWord),
  .eventsReady(eventsReady), .overflow(overflow), .busyPullDown(busyPullDown),
  .pushReq(ctrlStb.pushReq), .markStop(ctrlStb.markStop), .full(storeFull)
);

// File: tb/sim_evt_derand_writer.sv
module sim_evt_derand_writer;
  localparam int DATA_W = 10;
  localparam int TAG_W  = 4;
  localparam int LAT    = 4;
  localparam int DEPTH  = 32;
  localparam int CNT_W  = 12;
  localparam int OCC_W  = $clog2(DEPTH) + 1;
  localparam int WORD_W = DATA_W + TAG_W + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] sampleIn;
  logic [DATA_W-1:0] anaVal = '0;
  logic              startIn = 1'b0;
  logic              stopIn = 1'b0;
  logic [TAG_W-1:0]  tagIn = '0;
  logic [OCC_W-1:0]  afLevel = OCC_W'(DEPTH);
  logic              popIn = 1'b0;
  logic [WORD_W-1:0] rdWord;
  logic              rdValid;
  logic [CNT_W-1:0]  eventsReady;
  logic              almostFull;
  logic              busyPullDown;
  logic              overflow;

  int nChecks = 0;
  int nFail   = 0;
  bit popEnable = 1'b0;
  bit popOnce   = 1'b0;
  bit rawPop    = 1'b0;
  bit done      = 1'b0;
  logic [WORD_W-1:0] expQ [$];

  always #10 clk = ~clk;

  // ADC model: conversion result emerges LAT clocks after its sample
  logic [DATA_W-1:0] adcPipe [LAT];
  always @(posedge clk) begin
    adcPipe[0] <= anaVal;
    for (int i = 1; i < LAT; i++) adcPipe[i] <= adcPipe[i-1];
  end
  assign sampleIn = adcPipe[LAT-1];

  evt_derand_writer #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .ADC_LAT(LAT), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .startIn(startIn),
    .stopIn(stopIn), .tagIn(tagIn), .afLevel(afLevel), .popIn(popIn),
    .rdWord(rdWord), .rdValid(rdValid), .eventsReady(eventsReady),
    .almostFull(almostFull), .busyPullDown(busyPullDown), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // Monitor: pops words and compares them with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      popIn = 1'b0;
      if ((popEnable || popOnce) && rdValid) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL R3 unexpected word actual=%0h expected=none", rdWord);
        end else begin
          if (rdWord !== expQ[0]) begin
            nFail++;
            $display("FAIL R1 R2 R7 word actual=%0h expected=%0h", rdWord, expQ[0]);
          end
          void'(expQ.pop_front());
        end
        popIn = 1'b1;
        popOnce = 1'b0;
      end else if (rawPop) begin
        popIn = 1'b1;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      startIn = 1'b0; stopIn = 1'b0;
      anaVal = anaVal + 10'd91;   // samples outside events must not be stored
    end
  endtask

  task automatic sendEvent(input int len, input logic [TAG_W-1:0] tag, input int base);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      startIn = (k == 0);
      stopIn  = (k == len - 1);
      tagIn   = tag;
      anaVal  = DATA_W'(base + k * 37);
      if (expQ.size() < DEPTH)
        expQ.push_back({startIn, stopIn, tagIn, anaVal});
    end
    @(negedge clk);
    startIn = 1'b0; stopIn = 1'b0;
  endtask

  task automatic drain();
    popEnable = 1'b1;
    while (expQ.size() != 0) @(negedge clk);
    idle(3);
    popEnable = 1'b0;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rdValid == 1'b0, "R10 rdValid", rdValid, 0);
    check(eventsReady == 0, "R10 eventsReady", eventsReady, 0);
    check(overflow == 1'b0, "R10 overflow", overflow, 0);
    check(busyPullDown == 1'b0 && almostFull == 1'b0, "R10 busy", busyPullDown, 0);

    // R4 lone stop marker is ignored
    @(negedge clk); stopIn = 1'b1; anaVal = 10'd5;
    idle(LAT + 3);
    check(rdValid == 1'b0, "R4 no word stored", rdValid, 0);
    check(eventsReady == 0, "R4 count unchanged", eventsReady, 0);

    // R5 one event counted, R3 only framed words stored
    sendEvent(5, 4'h3, 100);
    idle(LAT + 3);
    check(eventsReady == 1, "R5 event counted", eventsReady, 1);
    check(rdValid == 1'b1, "R7 data visible", rdValid, 1);
    drain();
    check(rdValid == 1'b0, "R3 nothing outside event", rdValid, 0);
    check(eventsReady == 0, "R6 count after pop", eventsReady, 0);

    // R7 pop on empty has no effect
    @(posedge clk); rawPop = 1'b1;
    idle(3);
    @(posedge clk); rawPop = 1'b0;
    sendEvent(2, 4'hA, 300);
    idle(LAT + 3);
    check(eventsReady == 1, "R7 empty pop ignored count", eventsReady, 1);
    drain();
    check(rdValid == 1'b0, "R7 drained after empty pop", rdValid, 0);

    // R6 stop-word push and stop-word pop in the same cycle
    sendEvent(1, 4'h7, 500);
    idle(LAT + 3);
    check(eventsReady == 1, "R5 single-word event", eventsReady, 1);
    sendEvent(1, 4'h9, 700);     // drive in cycle c, returns after the next negedge
    @(negedge clk);
    @(negedge clk);
    @(posedge clk); popOnce = 1'b1;
    @(negedge clk);              // pop lands on the push edge
    @(negedge clk);
    check(eventsReady == 1, "R6 coincident inc/dec", eventsReady, 1);
    drain();
    check(eventsReady == 0, "R6 count after coincidence", eventsReady, 0);

    // Streaming with continuous popping
    popEnable = 1'b1;
    sendEvent(3, 4'h5, 11);
    sendEvent(1, 4'hC, 222);
    sendEvent(6, 4'h1, 333);
    sendEvent(2, 4'hF, 444);
    drain();
    check(eventsReady == 0, "R6 streaming count", eventsReady, 0);
    check(rdValid == 1'b0, "R7 streaming drained", rdValid, 0);

    // R8 almost-full threshold
    afLevel = OCC_W'(8);
    sendEvent(8, 4'h2, 50);
    idle(LAT + 3);
    check(busyPullDown == 1'b0, "R8 occupancy equal to level", busyPullDown, 0);
    sendEvent(1, 4'h4, 60);
    idle(LAT + 3);
    check(busyPullDown == 1'b1 && almostFull == 1'b1, "R8 occupancy above level", busyPullDown, 1);
    drain();
    check(busyPullDown == 1'b0, "R8 busy cleared", busyPullDown, 0);

    // R9 overflow: 40-word event into a 32-word FIFO
    sendEvent(40, 4'h6, 900);
    idle(LAT + 3);
    check(overflow == 1'b1, "R9 overflow set", overflow, 1);
    check(eventsReady == 0, "R9 dropped stop not counted", eventsReady, 0);
    check(busyPullDown == 1'b1, "R8 busy when full", busyPullDown, 1);
    drain();
    check(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
    check(rdValid == 1'b0, "R9 only DEPTH words kept", rdValid, 0);

    done = 1'b1;
    report();
  end
endmodule